// File: doc/BRIEF.md
# Clock stop controller

This block sits between the clock synthesizers and the output pins of a system clock generator. It receives one raw clock per output group and passes each one through a glitch-free gate. Three active-low controls decide which gates are open: a CPU stop, a PCI stop and a power-down.

The controls are first synchronized to the free-running PCI source clock. A small sequencer then forms one enable per group and passes it to the datapath. Power-down drops the oscillator/VCO enable, which goes to the analog section. Leaving power-down restarts a settle counter, and while it runs every group stays parked LOW. Each group gate re-synchronizes its enable into its own clock domain. The gate holds that enable in a latch while the clock is LOW, so a group only ever starts or stops between whole cycles.

Group bit order on both clock vectors: 0 CPU, 1 fixed 66 MHz, 2 CPU-half, 3 IOAPIC, 4 PCI (gated), 5 PCI free-running, 6 REF, 7 48 MHz.

Top module: `clock_stop_gate`

## Requirements
- R1: While `rstN` is LOW, every bit of `gClkOut` is LOW, `ready` is 0 and `oscEn` is 1. After `rstN` rises, `ready` rises at exactly the SETTLE_CYCLES-th rising edge of `grpClkIn[5]`, and no output pulses before that edge.
- R2: While `cpuStopN` is LOW, output bits 0 (CPU) and 1 (fixed 66 MHz) produce no pulses.
- R3: While `pciStopN` is LOW, output bit 4 (gated PCI) produces no pulses, and bit 5 (free-running PCI) keeps running.
- R4: Bits 2, 3, 5, 6 and 7 toggle at their source rate whenever `ready` is 1, whatever the stop inputs are. Bit 5 is not affected by either stop input.
- R5: With the default two-stage synchronizer, the last gated-PCI pulse after `pciStopN` falls is the one that starts on the 4th rising edge of `grpClkIn[5]`. After `pciStopN` rises again, the first pulse starts on the 5th edge.
- R6: After `pwrDownN` falls, `oscEn` and `ready` are both 0 after the 2nd rising edge of `grpClkIn[5]`. From then on, all eight outputs stay LOW.
- R7: After `pwrDownN` rises, `oscEn` returns to 1 at the 2nd free-running PCI edge, and `ready` returns at the (SETTLE_CYCLES+2)-th edge. No output pulses in between.
- R8: Every output high phase lasts exactly one full high phase of its source clock, so there are no runt pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| grpClkIn | input | 8 | Raw source clock per group, bit order as above |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuStopN | input | 1 | Active-low stop for CPU and fixed 66 MHz groups |
| pciStopN | input | 1 | Active-low stop for the gated PCI group |
| pwrDownN | input | 1 | Active-low power-down for every group |
| gClkOut | output | 8 | Gated clock per group, parked LOW when stopped |
| oscEn | output | 1 | Oscillator/VCO enable for the analog section |
| ready | output | 1 | Settle period over, groups allowed to run |

## Verification
A settle counter that is off by a count moves the rising edge of `ready` by one free-running PCI cycle, and the bench samples that edge exactly. A synchronizer stage too many or too few shifts the gated PCI pulse train by one edge inside an eight-edge window. A group enable stuck at the wrong level shows up within one 280 ns counting window, as a missing or extra pulse train on a group that should be the opposite. A gate that updates its enable during the high phase produces a shortened pulse, and the width monitor reports it on the falling edge of that pulse.

// File: rtl/clock_stop_pkg.sv
package clock_stop_pkg;

  localparam int NUM_GRP = 8;

  // group positions on the clock vectors
  localparam int GRP_CPU  = 0;
  localparam int GRP_V66  = 1;
  localparam int GRP_HALF = 2;
  localparam int GRP_APIC = 3;
  localparam int GRP_PCI  = 4;
  localparam int GRP_PCIF = 5;
  localparam int GRP_REF  = 6;
  localparam int GRP_USB  = 7;

  localparam logic [NUM_GRP-1:0] CPU_STOP_SET = NUM_GRP'((1 << GRP_CPU) | (1 << GRP_V66));
  localparam logic [NUM_GRP-1:0] PCI_STOP_SET = NUM_GRP'(1 << GRP_PCI);

  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_SETTLE = 2'd1,
    ST_RUN    = 2'd2
  } pwr_state_e;

  typedef struct packed {
    logic [NUM_GRP-1:0] grpEn;
    logic               oscEn;
    logic               ready;
  } ctrl_strobe_t;

endpackage

// File: rtl/clock_stop_fsm.sv
module clock_stop_fsm
  import clock_stop_pkg::*;
#(
  parameter int SETTLE_CYCLES = 100000
) (
  input  logic         pciClk,
  input  logic         rstN,
  input  logic         cpuStopN,
  input  logic         pciStopN,
  input  logic         pwrDownN,
  output ctrl_strobe_t strobes
);

  localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic cpuSyn, pciSyn, pwrSyn;
  pwr_state_e state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic [NUM_GRP-1:0] stopSet;
  ctrl_strobe_t strobeNext;

  // first capture stage; the strobe register is the second
  always_ff @(posedge pciClk or negedge rstN) begin
    if (!rstN) begin
      cpuSyn <= 1'b1;
      pciSyn <= 1'b1;
      pwrSyn <= 1'b1;
    end else begin
      cpuSyn <= cpuStopN;
      pciSyn <= pciStopN;
      pwrSyn <= pwrDownN;
    end
  end

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    if (!pwrSyn) begin
      stateNext = ST_OFF;
      cntNext   = '0;
    end else begin
      case (state)
        ST_OFF: begin
          stateNext = ST_SETTLE;
          cntNext   = '0;
        end
        ST_SETTLE: begin
          if (cnt == CNT_LAST) stateNext = ST_RUN;
          else                 cntNext   = cnt + CNT_W'(1);
        end
        ST_RUN:  stateNext = ST_RUN;
        default: stateNext = ST_OFF;
      endcase
    end
  end

  always_comb begin
    stopSet = '0;
    if (!cpuSyn) stopSet = stopSet | CPU_STOP_SET;
    if (!pciSyn) stopSet = stopSet | PCI_STOP_SET;
    strobeNext.oscEn = (stateNext != ST_OFF);
    strobeNext.ready = (stateNext == ST_RUN);
    strobeNext.grpEn = strobeNext.ready ? ~stopSet : '0;
  end

  always_ff @(posedge pciClk or negedge rstN) begin
    if (!rstN) begin
      state         <= ST_SETTLE;
      cnt           <= '0;
      strobes.grpEn <= '0;
      strobes.oscEn <= 1'b1;
      strobes.ready <= 1'b0;
    end else begin
      state   <= stateNext;
      cnt     <= cntNext;
      strobes <= strobeNext;
    end
  end

endmodule

// File: rtl/clock_stop_cell.sv
module clock_stop_cell #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clkIn,
  input  logic rstN,
  input  logic enReq,
  output logic clkOut
);

  logic enSync;
  logic enLat;

  generate
    if (SYNC_STAGES <= 1) begin : g_single
      logic q;
      always_ff @(posedge clkIn or negedge rstN) begin
        if (!rstN) q <= 1'b0;
        else       q <= enReq;
      end
      assign enSync = q;
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] q;
      always_ff @(posedge clkIn or negedge rstN) begin
        if (!rstN) q <= '0;
        else       q <= {q[SYNC_STAGES-2:0], enReq};
      end
      assign enSync = q[SYNC_STAGES-1];
    end
  endgenerate

  // enable may only move while the source clock is LOW
  always_latch begin
    if (!rstN)       enLat = 1'b0;
    else if (!clkIn) enLat = enSync;
  end

  assign clkOut = clkIn & enLat;

endmodule

// File: rtl/clock_stop_path.sv
module clock_stop_path
  import clock_stop_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic [NUM_GRP-1:0] grpClkIn,
  input  logic               rstN,
  input  ctrl_strobe_t       strobes,
  output logic [NUM_GRP-1:0] gClkOut,
  output logic               oscEn,
  output logic               ready
);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    clock_stop_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
      .clkIn (grpClkIn[g]),
      .rstN  (rstN),
      .enReq (strobes.grpEn[g]),
      .clkOut(gClkOut[g])
    );
  end

  assign oscEn = strobes.oscEn;
  assign ready = strobes.ready;

endmodule

// File: rtl/clock_stop_gate.sv
module clock_stop_gate
  import clock_stop_pkg::*;
#(
  parameter int SETTLE_CYCLES = 100000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic [NUM_GRP-1:0] grpClkIn,
  input  logic               rstN,
  input  logic               cpuStopN,
  input  logic               pciStopN,
  input  logic               pwrDownN,
  output logic [NUM_GRP-1:0] gClkOut,
  output logic               oscEn,
  output logic               ready
);

  ctrl_strobe_t ctrlBus;

  clock_stop_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_fsm (
    .pciClk  (grpClkIn[GRP_PCIF]),
    .rstN    (rstN),
    .cpuStopN(cpuStopN),
    .pciStopN(pciStopN),
    .pwrDownN(pwrDownN),
    .strobes (ctrlBus)
  );

  clock_stop_path #(.SYNC_STAGES(SYNC_STAGES)) u_path (
    .grpClkIn(grpClkIn),
    .rstN    (rstN),
    .strobes (ctrlBus),
    .gClkOut (gClkOut),
    .oscEn   (oscEn),
    .ready   (ready)
  );

endmodule

// File: rtl/clock_stop_chk.sv
module clock_stop_chk
  import clock_stop_pkg::*;
(
  input logic         pciClk,
  input logic         rstN,
  input logic         cpuStopN,
  input logic         pciStopN,
  input logic         pwrDownN,
  input ctrl_strobe_t strobes
);

  // R2
  cpu_stop_chk: assert property (@(posedge pciClk) disable iff (!rstN)
    !cpuStopN |-> ##2 !strobes.grpEn[GRP_CPU] && !strobes.grpEn[GRP_V66]);

  // R3
  pci_stop_chk: assert property (@(posedge pciClk) disable iff (!rstN)
    !pciStopN |-> ##2 !strobes.grpEn[GRP_PCI]);

  // R4
  free_pci_chk: assert property (@(posedge pciClk) disable iff (!rstN)
    $fell(strobes.grpEn[GRP_PCIF]) |-> !strobes.ready);

  // R6
  pwr_down_chk: assert property (@(posedge pciClk) disable iff (!rstN)
    !pwrDownN |-> ##2 !strobes.oscEn);

  // R7
  settle_first_chk: assert property (@(posedge pciClk) disable iff (!rstN)
    !strobes.oscEn |=> !strobes.ready);

endmodule

bind clock_stop_gate clock_stop_chk u_chk (
  .pciClk  (grpClkIn[clock_stop_pkg::GRP_PCIF]),
  .rstN    (rstN),
  .cpuStopN(cpuStopN),
  .pciStopN(pciStopN),
  .pwrDownN(pwrDownN),
  .strobes (ctrlBus)
);

// File: tb/clock_stop_gate_tb.sv
`timescale 1ns/1ps
module clock_stop_gate_tb;

  localparam int SETTLE = 16;
  localparam real WIN = 280.0;

  logic cpuC = 0, v66C = 0, halfC = 0, apicC = 0, pciClk = 0, refC = 0, usbC = 0;
  always #2   cpuC   = ~cpuC;
  always #3   v66C   = ~v66C;
  always #4   halfC  = ~halfC;
  always #10  apicC  = ~apicC;
  always #2.5 pciClk = ~pciClk;
  always #7   refC   = ~refC;
  always #5   usbC   = ~usbC;

  logic [7:0] grpClk;
  assign grpClk = {usbC, refC, pciClk, pciClk, apicC, halfC, v66C, cpuC};

  logic rstN = 0, cpuStopN = 1, pciStopN = 1, pwrDownN = 1;
  logic [7:0] gClkOut;
  logic oscEn, ready;

  clock_stop_gate #(.SETTLE_CYCLES(SETTLE), .SYNC_STAGES(2)) u_dut (
    .grpClkIn(grpClk), .rstN(rstN), .cpuStopN(cpuStopN), .pciStopN(pciStopN),
    .pwrDownN(pwrDownN), .gClkOut(gClkOut), .oscEn(oscEn), .ready(ready)
  );

  real halfNs [8] = '{2.0, 3.0, 4.0, 10.0, 2.5, 2.5, 7.0, 5.0};
  int pulseCnt [8] = '{0, 0, 0, 0, 0, 0, 0, 0};
  int runtBad [8] = '{0, 0, 0, 0, 0, 0, 0, 0};
  realtime riseAt [8];
  logic [7:0] prevOut = '0;

  // pulse counter and width monitor (R8)
  always @(gClkOut) begin
    for (int g = 0; g < 8; g++) begin
      if (gClkOut[g] && !prevOut[g]) begin
        pulseCnt[g] = pulseCnt[g] + 1;
        riseAt[g] = $realtime;
      end else if (!gClkOut[g] && prevOut[g]) begin
        if (($realtime - riseAt[g]) < halfNs[g] - 0.01 ||
            ($realtime - riseAt[g]) > halfNs[g] + 0.01) begin
          runtBad[g] = runtBad[g] + 1;
          $display("width error on group %0d: %0t", g, $realtime - riseAt[g]);
        end
      end
    end
    prevOut = gClkOut;
  end

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitPci(input int n);
    repeat (n) @(posedge pciClk);
    #1;
  endtask

  function automatic int totalPulses();
    int s = 0;
    for (int g = 0; g < 8; g++) s += pulseCnt[g];
    return s;
  endfunction

  task automatic sweepCombo(input int c);
    int base [8];
    bit en;
    real expc, d;
    @(posedge pciClk); #1;
    cpuStopN = c[0]; pciStopN = c[1]; pwrDownN = c[2];
    waitPci(SETTLE + 6);
    #70;
    check(ready == c[2], "R6/R7 ready in sweep", ready, c[2]);
    check(oscEn == c[2], "R6/R7 oscEn in sweep", oscEn, c[2]);
    for (int g = 0; g < 8; g++) base[g] = pulseCnt[g];
    #(WIN);
    for (int g = 0; g < 8; g++) begin
      en = c[2];
      if (!c[0] && (g == 0 || g == 1)) en = 0;
      if (!c[1] && g == 4) en = 0;
      if (en) begin
        expc = WIN / (2.0 * halfNs[g]);
        d = real'(pulseCnt[g] - base[g]) - expc;
        check(d <= 1.0 && d >= -1.0, "R2/R3/R4 running group count",
              pulseCnt[g] - base[g], $rtoi(expc));
      end else begin
        check(pulseCnt[g] == base[g], "R2/R3/R6 stopped group count",
              pulseCnt[g] - base[g], 0);
      end
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    int snap;
    int rb;
    // R1 reset state
    #20;
    check(gClkOut == 8'h00, "R1 outputs in reset", gClkOut, 0);
    check(ready == 1'b0, "R1 ready in reset", ready, 0);
    check(oscEn == 1'b1, "R1 oscEn in reset", oscEn, 1);
    #1 rstN = 1;
    waitPci(SETTLE - 1);
    check(ready == 1'b0, "R1 ready before settle end", ready, 0);
    check(totalPulses() == 0, "R1 no pulses during settle", totalPulses(), 0);
    waitPci(1);
    check(ready == 1'b1, "R1 ready at settle end", ready, 1);
    waitPci(20);

    // R5 exact gated PCI latency, R3 free PCI unaffected
    pciStopN = 0;
    for (int n = 1; n <= 8; n++) begin
      waitPci(1);
      check(gClkOut[4] == (n <= 4), "R5 gated PCI stop edge", gClkOut[4], n <= 4);
      check(gClkOut[5] == 1'b1, "R3 free PCI during stop", gClkOut[5], 1);
    end
    pciStopN = 1;
    for (int n = 1; n <= 8; n++) begin
      waitPci(1);
      check(gClkOut[4] == (n >= 5), "R5 gated PCI start edge", gClkOut[4], n >= 5);
    end

    // exhaustive sweep of the three controls (R2, R3, R4, R6)
    for (int c = 7; c >= 0; c--) sweepCombo(c);

    // R7 power-up sequence
    @(posedge pciClk); #1;
    cpuStopN = 1; pciStopN = 1; pwrDownN = 1;
    snap = totalPulses();
    waitPci(1);
    check(oscEn == 1'b0, "R7 oscEn after 1 edge", oscEn, 0);
    waitPci(1);
    check(oscEn == 1'b1, "R7 oscEn after 2 edges", oscEn, 1);
    check(ready == 1'b0, "R7 ready at settle start", ready, 0);
    waitPci(SETTLE - 1);
    check(ready == 1'b0, "R7 ready one edge early", ready, 0);
    check(totalPulses() == snap, "R7 no pulses while settling", totalPulses() - snap, 0);
    waitPci(1);
    check(ready == 1'b1, "R7 ready at settle end", ready, 1);
    waitPci(30);

    // R6 power-down entry
    pwrDownN = 0;
    waitPci(1);
    check(oscEn == 1'b1, "R6 oscEn after 1 edge", oscEn, 1);
    check(ready == 1'b1, "R6 ready after 1 edge", ready, 1);
    waitPci(1);
    check(oscEn == 1'b0, "R6 oscEn after 2 edges", oscEn, 0);
    check(ready == 1'b0, "R6 ready after 2 edges", ready, 0);
    waitPci(20);
    #70;
    snap = totalPulses();
    #200;
    check(totalPulses() == snap, "R6 all outputs quiet", totalPulses() - snap, 0);

    // R8 no runt pulse anywhere in the run
    rb = 0;
    for (int g = 0; g < 8; g++) rb += runtBad[g];
    check(rb == 0 && totalPulses() > 0, "R8 pulse widths", rb, 0);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule